// File: doc/BRIEF.md
# Windowed Register File with Overlapping Procedure Frames

This block holds the general registers of a processor core whose compiler passes arguments in registers instead of on a stack. An instruction always names one of 32 logical registers. The first ten are a global group that keeps its meaning at every call depth. The other 22 are a sliding frame, placed onto a circular pool of 128 storage words by a current window pointer. The storage totals 138 words of 32 bits. The frame has three parts. Logical 10..15 are the outgoing registers. Logical 16..25 are private to the procedure. Logical 26..31 are the incoming registers. When a call moves the pointer down by one bank of 16 words, the caller's outgoing registers become the callee's incoming registers, so arguments and results pass between the two procedures without any copy.

The register file has two read ports with one cycle of latency and one write port. Call and interrupt entry each move the pointer down one bank. Return moves it back up one bank; the same strobe serves a plain return and a return from an interrupt. A residency counter records how many frames are live on chip. One bank is kept free for interrupt entry, so plain calls are refused beyond seven resident frames. A refused call or return leaves the pointer unchanged and pulses a trap flag. The pointer and the counter are visible at the ports so that a handler can spill or refill banks in memory.

Top module: `winreg_file`

## Requirements
- R1: After synchronous reset the window pointer is 0, the resident count is 1, both trap flags are 0 and both read outputs are 0.
- R2: Logical register 0 always reads as 0. A write to logical register 0 changes no register.
- R3: Logical registers 1..9 are global storage. They return the same word at every window pointer value.
- R4: With pointer p, logical register L in 10..31 reaches pool word (16*p + L - 10) mod 128. The private registers 16..25 of different windows are therefore separate storage.
- R5: After a call, the callee's logical 26..31 are the same storage as the caller's logical 10..15, in that order, in both directions.
- R6: An accepted call or interrupt entry lowers the pointer by 1 mod 8 and raises the resident count by 1. An accepted return raises the pointer by 1 mod 8 and lowers the count by 1. Both take effect in the cycle after the strobe.
- R7: A call while the count is 7 is refused. The overflow flag is 1 for the following cycle, and the pointer and count hold.
- R8: Interrupt entry is accepted at count 7, which brings the count to 8. Interrupt entry at count 8 is refused in the same way as R7.
- R9: A return while the count is 1 is refused. The underflow flag is 1 for the following cycle, and the pointer and count hold.
- R10: When strobes occur together, interrupt entry takes priority over call, and call takes priority over return. Only the strobe that wins acts.
- R11: Both read ports deliver the addressed word one cycle after the address is applied. A read of the word being written in the same cycle returns the old value. The new value can be read from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_a_idx | input | 5 | Logical index for read port A |
| src_b_idx | input | 5 | Logical index for read port B |
| dst_idx | input | 5 | Logical index for the write |
| dst_wdata | input | 32 | Write data |
| dst_we | input | 1 | Write enable |
| call_req | input | 1 | Call strobe |
| ret_req | input | 1 | Return strobe (also used for return from interrupt) |
| trap_req | input | 1 | Interrupt entry strobe |
| src_a_q | output | 32 | Read data of port A, one cycle after the index |
| src_b_q | output | 32 | Read data of port B, one cycle after the index |
| wptr | output | 3 | Current window pointer |
| resident | output | 4 | Number of resident frames |
| ovf_trap | output | 1 | One-cycle pulse for a refused call or interrupt entry |
| unf_trap | output | 1 | One-cycle pulse for a refused return |

## Verification
A wrong pointer or mapping shows at the read ports one cycle after the next read. Words written in one window then come back with different values, or the wrong window's value comes back through the shared incoming and outgoing registers. A resident count that is off by one does not show at once. It stays hidden until the limit is reached, and then the overflow or underflow pulse arrives one strobe early or late. For that reason the bench takes the count all the way to both limits and checks each step. Mixed strobes expose a priority fault in the first cycle after them, through the pointer and the flags.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
  localparam int WRF_DATA_W  = 32;
  localparam int WRF_N_GLOB  = 10;
  localparam int WRF_N_SHARE = 6;
  localparam int WRF_N_LOCAL = 10;
  localparam int WRF_N_BANKS = 8;

  // Pointer operation chosen for the current cycle
  typedef enum logic [1:0] {
    WOP_HOLD = 2'd0,
    WOP_PUSH = 2'd1,
    WOP_POP  = 2'd2
  } win_op_e;
endpackage

// File: rtl/winreg_map.sv
// Logical index + window pointer -> physical storage word
module winreg_map #(
  parameter int N_GLOB    = 10,
  parameter int BANK_STEP = 16,
  parameter int N_BANKS   = 8,
  parameter int LA_W      = 5,
  parameter int PA_W      = 8,
  parameter int CWP_W     = 3
) (
  input  logic [LA_W-1:0]  log_idx,
  input  logic [CWP_W-1:0] cwp,
  output logic [PA_W-1:0]  phys
);
  localparam int POOL   = N_BANKS * BANK_STEP;
  localparam int N_PHYS = N_GLOB + POOL;

  int off;

  always_comb begin
    off = 0;
    if (log_idx < LA_W'(N_GLOB)) begin
      phys = PA_W'(log_idx);
    end else begin
      off  = (int'(cwp) * BANK_STEP + int'(log_idx) - N_GLOB) % POOL;
      phys = PA_W'(N_GLOB + off);
    end
    // R4: every mapped index stays inside the physical array
    a_r4_phys_range: assert (int'(phys) < N_PHYS);
  end
endmodule

// File: rtl/winreg_bank.sv
// One-write one-read storage copy, read-first, registered output
module winreg_bank #(
  parameter int DATA_W = 32,
  parameter int PA_W   = 8,
  parameter int DEPTH  = 138
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PA_W-1:0]   waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PA_W-1:0]   raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/winreg_ptr.sv
// Window pointer and resident-frame counter with trap pulses
module winreg_ptr
  import winreg_pkg::*;
#(
  parameter int N_BANKS = 8,
  parameter int CWP_W   = $clog2(N_BANKS),
  parameter int DEP_W   = $clog2(N_BANKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             call_req,
  input  logic             ret_req,
  input  logic             trap_req,
  output logic [CWP_W-1:0] wptr,
  output logic [DEP_W-1:0] resident,
  output logic             ovf_trap,
  output logic             unf_trap
);
  localparam logic [DEP_W-1:0] DEP_FULL = DEP_W'(N_BANKS);
  localparam logic [DEP_W-1:0] DEP_CALL = DEP_W'(N_BANKS - 1);
  localparam logic [DEP_W-1:0] DEP_ONE  = DEP_W'(1);

  win_op_e op;
  logic    ovf_n, unf_n;

  always_comb begin
    op    = WOP_HOLD;
    ovf_n = 1'b0;
    unf_n = 1'b0;
    if (trap_req) begin
      if (resident < DEP_FULL) op = WOP_PUSH;
      else                     ovf_n = 1'b1;
    end else if (call_req) begin
      if (resident < DEP_CALL) op = WOP_PUSH;
      else                     ovf_n = 1'b1;
    end else if (ret_req) begin
      if (resident > DEP_ONE)  op = WOP_POP;
      else                     unf_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      resident <= DEP_ONE;
      ovf_trap <= 1'b0;
      unf_trap <= 1'b0;
    end else begin
      ovf_trap <= ovf_n;
      unf_trap <= unf_n;
      case (op)
        WOP_PUSH: begin
          wptr     <= wptr - 1'b1;
          resident <= resident + 1'b1;
        end
        WOP_POP: begin
          wptr     <= wptr + 1'b1;
          resident <= resident - 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R6: count never leaves 1..N_BANKS
  a_r6_count_range: assert property (@(posedge clk) disable iff (rst)
    (resident >= DEP_ONE) && (resident <= DEP_FULL));

  // R6: accepted call steps the pointer down
  a_r6_call_step: assert property (@(posedge clk) disable iff (rst)
    (call_req && !trap_req && resident < DEP_CALL)
      |=> (wptr == CWP_W'($past(wptr) - 1'b1)) && !ovf_trap);

  // R7: call at the limit is refused
  a_r7_call_refused: assert property (@(posedge clk) disable iff (rst)
    (call_req && !trap_req && resident == DEP_CALL)
      |=> ovf_trap && $stable(wptr) && $stable(resident));

  // R8: interrupt entry may use the reserved bank
  a_r8_trap_reserve: assert property (@(posedge clk) disable iff (rst)
    (trap_req && resident == DEP_CALL) |=> !ovf_trap && resident == DEP_FULL);

  // R9: return with no resident caller is refused
  a_r9_ret_refused: assert property (@(posedge clk) disable iff (rst)
    (ret_req && !call_req && !trap_req && resident == DEP_ONE)
      |=> unf_trap && $stable(wptr));

  // R10: a return beside a call never pops
  a_r10_call_beats_ret: assert property (@(posedge clk) disable iff (rst)
    (call_req && ret_req) |=> !unf_trap && (resident != $past(resident) - 1'b1));
endmodule

// File: rtl/winreg_file.sv
module winreg_file
  import winreg_pkg::*;
#(
  parameter int DATA_W  = WRF_DATA_W,
  parameter int N_GLOB  = WRF_N_GLOB,
  parameter int N_SHARE = WRF_N_SHARE,
  parameter int N_LOCAL = WRF_N_LOCAL,
  parameter int N_BANKS = WRF_N_BANKS
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [$clog2(N_GLOB+2*N_SHARE+N_LOCAL)-1:0] src_a_idx,
  input  logic [$clog2(N_GLOB+2*N_SHARE+N_LOCAL)-1:0] src_b_idx,
  input  logic [$clog2(N_GLOB+2*N_SHARE+N_LOCAL)-1:0] dst_idx,
  input  logic [DATA_W-1:0]                  dst_wdata,
  input  logic                               dst_we,
  input  logic                               call_req,
  input  logic                               ret_req,
  input  logic                               trap_req,
  output logic [DATA_W-1:0]                  src_a_q,
  output logic [DATA_W-1:0]                  src_b_q,
  output logic [$clog2(N_BANKS)-1:0]         wptr,
  output logic [$clog2(N_BANKS+1)-1:0]       resident,
  output logic                               ovf_trap,
  output logic                               unf_trap
);
  localparam int LOG_REGS  = N_GLOB + 2 * N_SHARE + N_LOCAL;
  localparam int BANK_STEP = N_SHARE + N_LOCAL;
  localparam int N_PHYS    = N_GLOB + N_BANKS * BANK_STEP;
  localparam int LA_W      = $clog2(LOG_REGS);
  localparam int PA_W      = $clog2(N_PHYS);
  localparam int CWP_W     = $clog2(N_BANKS);
  localparam int DEP_W     = $clog2(N_BANKS + 1);
  localparam int N_RD      = 2;

  logic [LA_W-1:0]   rd_idx  [N_RD];
  logic [PA_W-1:0]   rd_phys [N_RD];
  logic [DATA_W-1:0] bank_q  [N_RD];
  logic              zero_q  [N_RD];
  logic [PA_W-1:0]   wr_phys;
  logic              wr_en;

  assign rd_idx[0] = src_a_idx;
  assign rd_idx[1] = src_b_idx;
  assign wr_en     = dst_we && (dst_idx != '0);

  winreg_ptr #(.N_BANKS(N_BANKS), .CWP_W(CWP_W), .DEP_W(DEP_W)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .call_req (call_req),
    .ret_req  (ret_req),
    .trap_req (trap_req),
    .wptr     (wptr),
    .resident (resident),
    .ovf_trap (ovf_trap),
    .unf_trap (unf_trap)
  );

  winreg_map #(.N_GLOB(N_GLOB), .BANK_STEP(BANK_STEP), .N_BANKS(N_BANKS),
               .LA_W(LA_W), .PA_W(PA_W), .CWP_W(CWP_W)) u_wmap (
    .log_idx (dst_idx),
    .cwp     (wptr),
    .phys    (wr_phys)
  );

  // One storage copy per read port, all written together
  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    winreg_map #(.N_GLOB(N_GLOB), .BANK_STEP(BANK_STEP), .N_BANKS(N_BANKS),
                 .LA_W(LA_W), .PA_W(PA_W), .CWP_W(CWP_W)) u_rmap (
      .log_idx (rd_idx[p]),
      .cwp     (wptr),
      .phys    (rd_phys[p])
    );

    winreg_bank #(.DATA_W(DATA_W), .PA_W(PA_W), .DEPTH(N_PHYS)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (wr_en),
      .waddr (wr_phys),
      .wdata (dst_wdata),
      .raddr (rd_phys[p]),
      .rdata (bank_q[p])
    );

    always_ff @(posedge clk) begin
      if (rst) zero_q[p] <= 1'b1;
      else     zero_q[p] <= (rd_idx[p] == '0);
    end
  end

  assign src_a_q = zero_q[0] ? '0 : bank_q[0];
  assign src_b_q = zero_q[1] ? '0 : bank_q[1];

  // R2: index 0 on either port yields zero on the next cycle
  a_r2_zero_a: assert property (@(posedge clk) disable iff (rst)
    (src_a_idx == '0) |=> (src_a_q == '0));
  a_r2_zero_b: assert property (@(posedge clk) disable iff (rst)
    (src_b_idx == '0) |=> (src_b_q == '0));

  // R3: two global indices read alike on both ports when equal
  a_r3_ports_agree: assert property (@(posedge clk) disable iff (rst)
    (src_a_idx == src_b_idx) |=> (src_a_q == src_b_q));
endmodule

// File: tb/winreg_file_test.sv
`timescale 1ns/1ps
module winreg_file_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  src_a_idx = '0, src_b_idx = '0, dst_idx = '0;
  logic [31:0] dst_wdata = '0;
  logic        dst_we = 1'b0, call_req = 1'b0, ret_req = 1'b0, trap_req = 1'b0;
  logic [31:0] src_a_q, src_b_q;
  logic [2:0]  wptr;
  logic [3:0]  resident;
  logic        ovf_trap, unf_trap;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  winreg_file uut (
    .clk(clk), .rst(rst),
    .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .dst_idx(dst_idx), .dst_wdata(dst_wdata), .dst_we(dst_we),
    .call_req(call_req), .ret_req(ret_req), .trap_req(trap_req),
    .src_a_q(src_a_q), .src_b_q(src_b_q),
    .wptr(wptr), .resident(resident),
    .ovf_trap(ovf_trap), .unf_trap(unf_trap)
  );

  // Model state built from the requirements
  logic [31:0] m_mem   [138];
  bit          m_known [138];
  int          m_cwp   = 0;
  int          m_dep   = 1;
  bit          m_ovf   = 0;
  bit          m_unf   = 0;

  function automatic int phys_of(int l, int cwp);
    if (l < 10) return l;
    return 10 + ((cwp * 16 + l - 10) % 128);
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // Called at a negedge: drive, advance one cycle, check at the next negedge
  task automatic op(input bit we, input int wa, input logic [31:0] wd,
                    input int ra, input int rb, input bit c, input bit r, input bit i,
                    input string ctag, input string dtag);
    logic [31:0] ea, eb;
    bit ka, kb;
    ka = (ra == 0) || m_known[phys_of(ra, m_cwp)];
    kb = (rb == 0) || m_known[phys_of(rb, m_cwp)];
    ea = (ra == 0) ? 32'h0 : m_mem[phys_of(ra, m_cwp)];
    eb = (rb == 0) ? 32'h0 : m_mem[phys_of(rb, m_cwp)];
    if (we && wa != 0) begin
      m_mem[phys_of(wa, m_cwp)]   = wd;
      m_known[phys_of(wa, m_cwp)] = 1'b1;
    end
    m_ovf = 0; m_unf = 0;
    if (i) begin
      if (m_dep < 8) begin m_cwp = (m_cwp + 7) % 8; m_dep++; end else m_ovf = 1;
    end else if (c) begin
      if (m_dep < 7) begin m_cwp = (m_cwp + 7) % 8; m_dep++; end else m_ovf = 1;
    end else if (r) begin
      if (m_dep > 1) begin m_cwp = (m_cwp + 1) % 8; m_dep--; end else m_unf = 1;
    end
    dst_we = we; dst_idx = 5'(wa); dst_wdata = wd;
    src_a_idx = 5'(ra); src_b_idx = 5'(rb);
    call_req = c; ret_req = r; trap_req = i;
    @(negedge clk);
    dst_we = 0; call_req = 0; ret_req = 0; trap_req = 0;
    chk(ctag, {wptr, resident, ovf_trap, unf_trap},
        {3'(m_cwp), 4'(m_dep), m_ovf, m_unf});
    if (ka) chk(dtag, src_a_q, ea);
    if (kb) chk(dtag, src_b_q, eb);
  endtask

  localparam int NV = 10;
  localparam logic [4:0] VEC_IDX [NV] = '{5'd0, 5'd3, 5'd9, 5'd10, 5'd15,
                                          5'd16, 5'd21, 5'd25, 5'd26, 5'd31};

  initial begin
    for (int k = 0; k < 138; k++) begin m_mem[k] = '0; m_known[k] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", {wptr, resident, ovf_trap, unf_trap, src_a_q, src_b_q},
        {3'd0, 4'd1, 1'b0, 1'b0, 32'h0, 32'h0});
    rst = 1'b0;

    // Vector table at window 0: writes, then paired reads
    for (int k = 0; k < NV; k++)
      op(1, int'(VEC_IDX[k]), 32'hA500_0000 + 32'(k) * 32'h1111, 0, 0, 0, 0, 0, "R6", "R2");
    for (int k = 0; k < NV; k++)
      op(0, 0, 0, int'(VEC_IDX[k]), int'(VEC_IDX[(k + 1) % NV]), 0, 0, 0, "R6", "R4");
    // R2: written index 0 still reads zero on both ports
    op(0, 0, 0, 0, 0, 0, 0, 0, "R6", "R2");

    // R11: read during write returns old, next cycle returns new
    op(1, 20, 32'h1111_0000, 0, 0, 0, 0, 0, "R6", "R11");
    op(1, 20, 32'h2222_0000, 20, 20, 0, 0, 0, "R6", "R11");
    op(0, 0, 0, 20, 20, 0, 0, 0, "R6", "R11");

    // R6: call, then R5 overlap and R3 globals in the callee
    op(0, 0, 0, 0, 0, 1, 0, 0, "R6", "R6");
    op(0, 0, 0, 26, 31, 0, 0, 0, "R6", "R5");
    op(0, 0, 0, 3, 9, 0, 0, 0, "R6", "R3");
    op(1, 16, 32'hC0DE_0016, 0, 0, 0, 0, 0, "R6", "R4");
    op(1, 31, 32'hC0DE_0031, 16, 0, 0, 0, 0, "R6", "R4");
    op(0, 0, 0, 0, 0, 0, 1, 0, "R6", "R6");
    // R4: caller private 16 untouched; R5: caller 15 sees callee 31
    op(0, 0, 0, 16, 15, 0, 0, 0, "R6", "R4");
    op(0, 0, 0, 15, 16, 0, 0, 0, "R6", "R5");

    // Fill to 7 resident frames
    for (int k = 0; k < 6; k++) op(0, 0, 0, 9, 3, 1, 0, 0, "R6", "R3");
    op(0, 0, 0, 0, 0, 1, 0, 0, "R7", "R7");   // R7: refused call
    op(0, 0, 0, 0, 0, 0, 0, 1, "R8", "R8");   // R8: reserve bank used
    op(0, 0, 0, 3, 9, 0, 0, 1, "R8", "R3");   // R8: refused at 8
    op(0, 0, 0, 0, 0, 1, 0, 0, "R7", "R7");   // R7: refused at 8 too
    op(0, 0, 0, 0, 0, 1, 1, 0, "R10", "R10"); // R10: call beats return
    op(0, 0, 0, 0, 0, 1, 1, 1, "R10", "R10"); // R10: interrupt beats both

    // Unwind to 1 frame, then underflow
    for (int k = 0; k < 7; k++) op(0, 0, 0, 0, 0, 0, 1, 0, "R6", "R6");
    op(0, 0, 0, 16, 15, 0, 0, 0, "R6", "R4");
    op(0, 0, 0, 0, 0, 0, 1, 0, "R9", "R9");   // R9: refused return
    op(0, 0, 0, 0, 0, 1, 1, 0, "R10", "R10"); // R10: call wins at depth 1
    op(0, 0, 0, 0, 0, 1, 0, 1, "R10", "R10"); // R10: single step for two strobes
    op(0, 0, 0, 26, 31, 0, 0, 0, "R6", "R5");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule